// File: doc/BRIEF.md
# Ethernet Pause Flow Control Unit

This block handles both directions of MAC-level pause flow control. On the receive side it watches a parsed-frame interface that delivers the type field, opcode and first payload word of each frame together with a one-cycle valid strobe. A frame that is a pause request loads a countdown timer, and the timer counts down in units of 512 bit times, paced by a bit-time tick input. While the timer runs, the block raises a hold indication that tells the transmit frame assembler not to start any new frame. A frame already in flight is left to finish.

On the transmit side it builds pause requests of its own. A request comes from a hardware XOFF input, taken on its rising edge and maskable by a configuration bit, or from a one-cycle software command. The request waits until the assembler reports that no frame is in progress. The block then emits the pause frame as a byte stream, without the FCS, carrying the programmed quanta. The receive FIFO level plays no part in this decision. A configuration bit makes the receive side disregard incoming pause requests completely.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A strobe on `rx_frm_valid` with `rx_len_type` = 0x8808, `rx_opcode` = 0x0001 and nonzero `rx_quanta` sets `pause_running` two clock edges later.
- R2: A strobe whose type is not 0x8808, or whose opcode is not 0x0001, leaves `pause_running` low.
- R3: With `bit_tick` high on every cycle, a pause of quanta Q keeps `pause_running` high for exactly Q×512 cycles, counted from the cycle after the load.
- R4: The timer only advances on cycles with `bit_tick` high. With the tick held low, `pause_running` stays high indefinitely.
- R5: A pause with quanta 0 clears `pause_running` two edges after its strobe, even in the middle of a countdown.
- R6: A new pause replaces the remaining time. After a reload with quanta Q, `pause_running` lasts exactly Q×512 ticks from the reload.
- R7: While `cfg_ignore_pause` is 1, received pause frames do not raise `pause_running`.
- R8: `tx_hold` is high whenever `pause_running` is high, and whenever a generated pause frame is pending or being emitted.
- R9: A pending generated frame does not start while `tx_frame_busy` is high. It starts once the signal falls.
- R10: A generated frame is 60 contiguous bytes with `gen_valid` high. `gen_sop` marks byte 0 and `gen_eop` marks byte 59. Bytes 0–5 are 01 80 C2 00 00 01. Bytes 6–11 are `local_mac` with bits 47:40 first. Bytes 12–15 are 88 08 00 01. Bytes 16–17 are the quanta, high byte first. Bytes 18–59 are 00.
- R11: A one-cycle `cfg_xoff_cmd` always requests one frame. A rising edge of `xoff_req` requests one frame only while `cfg_xoff_hw_disable` is 0, and holding `xoff_req` high gives no further frames.
- R12: The quanta placed in a generated frame is `cfg_quanta` as sampled when the frame starts. Later changes do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One pulse per line bit time |
| rx_frm_valid | input | 1 | Parsed receive fields valid strobe |
| rx_len_type | input | 16 | Length/type field of received frame |
| rx_opcode | input | 16 | Control opcode of received frame |
| rx_quanta | input | 16 | First payload word after the opcode |
| cfg_ignore_pause | input | 1 | Disregard received pause requests |
| cfg_quanta | input | 16 | Quanta for generated pause frames |
| cfg_xoff_cmd | input | 1 | Software pause-generate pulse |
| cfg_xoff_hw_disable | input | 1 | Mask for the hardware XOFF input |
| xoff_req | input | 1 | Hardware XOFF request (rising edge) |
| local_mac | input | 48 | Station address used as source |
| tx_frame_busy | input | 1 | Assembler is sending a frame |
| pause_running | output | 1 | Receive pause timer is nonzero |
| tx_hold | output | 1 | Do not start a new user frame |
| gen_valid | output | 1 | Generated frame byte valid |
| gen_data | output | 8 | Generated frame byte |
| gen_sop | output | 1 | First byte of generated frame |
| gen_eop | output | 1 | Last byte of generated frame |

## Verification
The hardest case to reach is a reload that lands partway through a quantum. The sub-quantum counter must restart there, otherwise the new duration is short by a fraction of 512 ticks. The stimulus runs a three-quanta pause for 600 ticks, which is past one full quantum and partway into the second, then sends a one-quantum pause and counts the cycles until `pause_running` falls. A second difficult case is a generation request that meets a busy assembler. The bench holds `tx_frame_busy` high across the command and watches that no byte appears until it falls.

// File: rtl/pfc_pkg.sv
// Shared constants and the byte layout function for pause frames.
// Assumes a 16-bit quanta and a 48-bit station address.
package pfc_pkg;
    localparam logic [15:0] PAUSE_TYPE   = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
    localparam logic [47:0] PAUSE_DA     = 48'h0180_C200_0001;

    // Returns the byte at position idx of a pause frame (FCS excluded).
    function automatic logic [7:0] pause_byte(input logic [7:0] idx,
                                              input logic [47:0] mac,
                                              input logic [15:0] q);
        logic [7:0] b;
        b = 8'h00;
        if (idx < 8'd6)
            b = 8'(PAUSE_DA >> (8 * (5 - int'(idx))));
        else if (idx < 8'd12)
            b = 8'(mac >> (8 * (11 - int'(idx))));
        else begin
            case (idx)
                8'd12:   b = PAUSE_TYPE[15:8];
                8'd13:   b = PAUSE_TYPE[7:0];
                8'd14:   b = PAUSE_OPCODE[15:8];
                8'd15:   b = PAUSE_OPCODE[7:0];
                8'd16:   b = q[15:8];
                8'd17:   b = q[7:0];
                default: b = 8'h00;
            endcase
        end
        return b;
    endfunction
endpackage

// File: rtl/pfc_rx_decode.sv
// Recognises pause requests in the parsed receive fields and registers a
// one-cycle load strobe with its quanta. Assumes the fields are valid
// only in the cycle rx_frm_valid is high.
module pfc_rx_decode #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_frm_valid,
    input  logic [15:0]   rx_len_type,
    input  logic [15:0]   rx_opcode,
    input  logic [QW-1:0] rx_quanta,
    input  logic          cfg_ignore_pause,
    output logic          load_vld,
    output logic [QW-1:0] load_quanta
);
    import pfc_pkg::*;

    logic is_pause;
    assign is_pause = rx_frm_valid && (rx_len_type == PAUSE_TYPE) &&
                      (rx_opcode == PAUSE_OPCODE) && !cfg_ignore_pause;

    // Register the filtered load request and its quanta.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_vld    <= 1'b0;
            load_quanta <= '0;
        end else begin
            load_vld    <= is_pause;
            load_quanta <= rx_quanta;
        end
    end
endmodule

// File: rtl/pfc_pause_timer.sv
// Pause countdown: a quanta counter decremented once every QUANTUM_BITS
// bit ticks. A load replaces the whole state. Assumes QUANTUM_BITS is a
// power of two.
module pfc_pause_timer #(
    parameter int QW           = 16,
    parameter int QUANTUM_BITS = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_vld,
    input  logic [QW-1:0] load_quanta,
    input  logic          bit_tick,
    output logic          running
);
    localparam int SUB_W = $clog2(QUANTUM_BITS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(QUANTUM_BITS - 1);

    logic [QW-1:0]    quanta_left;
    logic [SUB_W-1:0] sub_cnt;

    // Load, or advance the two-level countdown on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quanta_left <= '0;
            sub_cnt     <= '0;
        end else if (load_vld) begin
            quanta_left <= load_quanta;
            sub_cnt     <= '0;
        end else if (bit_tick && (quanta_left != '0)) begin
            if (sub_cnt == SUB_LAST) begin
                sub_cnt     <= '0;
                quanta_left <= quanta_left - 1'b1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end

    assign running = (quanta_left != '0);
endmodule

// File: rtl/pfc_gen_ctrl.sv
// Pause-frame generator: collects hardware and software requests, waits
// for the assembler to be idle, then emits one frame as a byte stream.
// Assumes FRAME_BYTES <= 256 and that the consumer takes a byte per cycle.
module pfc_gen_ctrl #(
    parameter int QW          = 16,
    parameter int FRAME_BYTES = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xoff_req,
    input  logic          cfg_xoff_hw_disable,
    input  logic          cfg_xoff_cmd,
    input  logic [QW-1:0] cfg_quanta,
    input  logic [47:0]   local_mac,
    input  logic          tx_frame_busy,
    output logic          gen_pending,
    output logic          gen_valid,
    output logic [7:0]    gen_data,
    output logic          gen_sop,
    output logic          gen_eop
);
    import pfc_pkg::*;

    localparam int IDX_W = $clog2(FRAME_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    logic             xoff_q;
    logic             pending_q;
    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [QW-1:0]    quanta_q;
    logic             req;
    logic             start;

    assign req   = cfg_xoff_cmd || (xoff_req && !xoff_q && !cfg_xoff_hw_disable);
    assign start = pending_q && !active_q && !tx_frame_busy;

    // Track the request, the emission state and the latched quanta.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_q    <= 1'b0;
            pending_q <= 1'b0;
            active_q  <= 1'b0;
            idx_q     <= '0;
            quanta_q  <= '0;
        end else begin
            xoff_q    <= xoff_req;
            pending_q <= (pending_q && !start) || req;
            if (start) begin
                active_q <= 1'b1;
                idx_q    <= '0;
                quanta_q <= cfg_quanta;
            end else if (active_q) begin
                if (idx_q == IDX_LAST) active_q <= 1'b0;
                else                   idx_q    <= idx_q + 1'b1;
            end
        end
    end

    // Present the current byte and its frame markers.
    always_comb begin
        gen_valid = active_q;
        gen_sop   = active_q && (idx_q == '0);
        gen_eop   = active_q && (idx_q == IDX_LAST);
        gen_data  = active_q ? pause_byte(8'(idx_q), local_mac, 16'(quanta_q)) : 8'h00;
    end

    assign gen_pending = pending_q;
endmodule

// File: rtl/pause_flow_ctrl.sv
// Top of the pause flow control unit: receive decode, pause timer and
// pause-frame generator, plus the transmit hold output. Assumes the
// assembler samples tx_hold only before starting a new frame.
module pause_flow_ctrl #(
    parameter int QW           = 16,
    parameter int QUANTUM_BITS = 512,
    parameter int FRAME_BYTES  = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          rx_frm_valid,
    input  logic [15:0]   rx_len_type,
    input  logic [15:0]   rx_opcode,
    input  logic [QW-1:0] rx_quanta,
    input  logic          cfg_ignore_pause,
    input  logic [QW-1:0] cfg_quanta,
    input  logic          cfg_xoff_cmd,
    input  logic          cfg_xoff_hw_disable,
    input  logic          xoff_req,
    input  logic [47:0]   local_mac,
    input  logic          tx_frame_busy,
    output logic          pause_running,
    output logic          tx_hold,
    output logic          gen_valid,
    output logic [7:0]    gen_data,
    output logic          gen_sop,
    output logic          gen_eop
);
    logic          load_vld;
    logic [QW-1:0] load_quanta;
    logic          gen_pending;

    pfc_rx_decode #(.QW(QW)) u_dec (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_frm_valid     (rx_frm_valid),
        .rx_len_type      (rx_len_type),
        .rx_opcode        (rx_opcode),
        .rx_quanta        (rx_quanta),
        .cfg_ignore_pause (cfg_ignore_pause),
        .load_vld         (load_vld),
        .load_quanta      (load_quanta)
    );

    pfc_pause_timer #(.QW(QW), .QUANTUM_BITS(QUANTUM_BITS)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_vld    (load_vld),
        .load_quanta (load_quanta),
        .bit_tick    (bit_tick),
        .running     (pause_running)
    );

    pfc_gen_ctrl #(.QW(QW), .FRAME_BYTES(FRAME_BYTES)) u_gen (
        .clk                 (clk),
        .rst_n               (rst_n),
        .xoff_req            (xoff_req),
        .cfg_xoff_hw_disable (cfg_xoff_hw_disable),
        .cfg_xoff_cmd        (cfg_xoff_cmd),
        .cfg_quanta          (cfg_quanta),
        .local_mac           (local_mac),
        .tx_frame_busy       (tx_frame_busy),
        .gen_pending         (gen_pending),
        .gen_valid           (gen_valid),
        .gen_data            (gen_data),
        .gen_sop             (gen_sop),
        .gen_eop             (gen_eop)
    );

    // Hold off new user frames while paused or while a pause frame is owed.
    assign tx_hold = pause_running || gen_pending || gen_valid;
endmodule

// File: rtl/pause_flow_ctrl_chk.sv
// Checker for pause_flow_ctrl: port-level properties, bound to the top.
module pause_flow_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_ignore_pause,
    input logic tx_frame_busy,
    input logic pause_running,
    input logic tx_hold,
    input logic gen_valid,
    input logic gen_sop,
    input logic gen_eop
);
    p_hold_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pause_running |-> tx_hold);
    p_hold_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gen_valid |-> tx_hold);
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gen_sop |-> $past(!tx_frame_busy));
    p_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_sop || gen_eop) |-> gen_valid);
    p_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid && !gen_eop) |=> (gen_valid && !gen_sop));
    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ignore_pause && $past(cfg_ignore_pause) && !pause_running) |=> !pause_running);
endmodule

bind pause_flow_ctrl pause_flow_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_ignore_pause (cfg_ignore_pause),
    .tx_frame_busy    (tx_frame_busy),
    .pause_running    (pause_running),
    .tx_hold          (tx_hold),
    .gen_valid        (gen_valid),
    .gen_sop          (gen_sop),
    .gen_eop          (gen_eop)
);

// File: tb/pause_flow_ctrl_tb.sv
module pause_flow_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b1;
    logic        rx_frm_valid = 1'b0;
    logic [15:0] rx_len_type = '0;
    logic [15:0] rx_opcode = '0;
    logic [15:0] rx_quanta = '0;
    logic        cfg_ignore_pause = 1'b0;
    logic [15:0] cfg_quanta = '0;
    logic        cfg_xoff_cmd = 1'b0;
    logic        cfg_xoff_hw_disable = 1'b0;
    logic        xoff_req = 1'b0;
    logic [47:0] local_mac = 48'h02_11_22_33_44_55;
    logic        tx_frame_busy = 1'b0;
    logic        pause_running, tx_hold, gen_valid, gen_sop, gen_eop;
    logic [7:0]  gen_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .rx_frm_valid(rx_frm_valid), .rx_len_type(rx_len_type),
        .rx_opcode(rx_opcode), .rx_quanta(rx_quanta),
        .cfg_ignore_pause(cfg_ignore_pause), .cfg_quanta(cfg_quanta),
        .cfg_xoff_cmd(cfg_xoff_cmd), .cfg_xoff_hw_disable(cfg_xoff_hw_disable),
        .xoff_req(xoff_req), .local_mac(local_mac), .tx_frame_busy(tx_frame_busy),
        .pause_running(pause_running), .tx_hold(tx_hold), .gen_valid(gen_valid),
        .gen_data(gen_data), .gen_sop(gen_sop), .gen_eop(gen_eop)
    );

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [15:0] q);
        logic [7:0] da [6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
        if (i < 6)  return da[i];
        if (i < 12) return local_mac[47 - 8*(i-6) -: 8];
        case (i)
            12: return 8'h88;
            13: return 8'h08;
            14: return 8'h00;
            15: return 8'h01;
            16: return q[15:8];
            17: return q[7:0];
            default: return 8'h00;
        endcase
    endfunction

    // Drive one parsed-frame strobe; returns after the decode edge.
    task automatic send_frame(input logic [15:0] t, input logic [15:0] op,
                              input logic [15:0] q);
        rx_len_type = t; rx_opcode = op; rx_quanta = q; rx_frm_valid = 1'b1;
        @(negedge clk);
        rx_frm_valid = 1'b0;
    endtask

    task automatic count_running(output int n);
        n = 0;
        while (pause_running && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_cmd();
        cfg_xoff_cmd = 1'b1;
        @(negedge clk);
        cfg_xoff_cmd = 1'b0;
    endtask

    // Wait for a frame and compare all bytes; optionally change cfg_quanta at sop.
    task automatic capture(input string req, input logic [15:0] q,
                           input bit change_q, input logic [15:0] new_q);
        int w = 0;
        int bad = 0;
        while (!gen_sop && w < 500) begin w++; @(negedge clk); end
        check_eq(req, "frame started", gen_sop, 1);
        if (change_q) cfg_quanta = new_q;
        for (int i = 0; i < 60; i++) begin
            if (gen_valid !== 1'b1 || gen_data !== exp_byte(i, q) ||
                gen_eop !== (i == 59) || gen_sop !== (i == 0)) begin
                bad++;
                $display("FAIL %s byte %0d actual=%0h expected=%0h", req, i, gen_data, exp_byte(i, q));
            end
            @(negedge clk);
        end
        checks++;
        if (bad != 0) errors++;
        check_eq(req, "valid after eop", gen_valid, 0);
    endtask

    task automatic t_reset();
        check_eq("R1", "running at reset", pause_running, 0);
        check_eq("R8", "hold at reset", tx_hold, 0);
        check_eq("R10", "gen_valid at reset", gen_valid, 0);
    endtask

    task automatic t_basic();
        int n;
        send_frame(16'h8808, 16'h0001, 16'd2);
        @(negedge clk);
        check_eq("R1", "running after pause", pause_running, 1);
        check_eq("R8", "hold while running", tx_hold, 1);
        count_running(n);
        check_eq("R3", "duration q=2", n, 1024);
    endtask

    task automatic t_reject();
        send_frame(16'h0800, 16'h0001, 16'd5);
        repeat (2) @(negedge clk);
        check_eq("R2", "wrong type", pause_running, 0);
        send_frame(16'h8808, 16'h0002, 16'd5);
        repeat (2) @(negedge clk);
        check_eq("R2", "wrong opcode", pause_running, 0);
    endtask

    task automatic t_ignore();
        cfg_ignore_pause = 1'b1;
        @(negedge clk);
        send_frame(16'h8808, 16'h0001, 16'd4);
        repeat (3) @(negedge clk);
        check_eq("R7", "ignored pause", pause_running, 0);
        check_eq("R7", "hold when ignored", tx_hold, 0);
        cfg_ignore_pause = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_tick();
        int n;
        bit_tick = 1'b0;
        send_frame(16'h8808, 16'h0001, 16'd1);
        @(negedge clk);
        repeat (2000) @(negedge clk);
        check_eq("R4", "no tick keeps running", pause_running, 1);
        bit_tick = 1'b1;
        count_running(n);
        check_eq("R4", "ticks after resume", n, 512);
    endtask

    task automatic t_zero();
        send_frame(16'h8808, 16'h0001, 16'd5);
        repeat (100) @(negedge clk);
        check_eq("R5", "running before cancel", pause_running, 1);
        send_frame(16'h8808, 16'h0001, 16'd0);
        @(negedge clk);
        check_eq("R5", "zero quanta cancels", pause_running, 0);
    endtask

    task automatic t_reload();
        int n;
        send_frame(16'h8808, 16'h0001, 16'd3);
        @(negedge clk);
        repeat (600) @(negedge clk);
        check_eq("R6", "running before reload", pause_running, 1);
        send_frame(16'h8808, 16'h0001, 16'd1);
        @(negedge clk);
        count_running(n);
        check_eq("R6", "duration after reload", n, 512);
    endtask

    task automatic t_gen_cmd();
        cfg_quanta = 16'h1234;
        pulse_cmd();
        capture("R10", 16'h1234, 1'b0, 16'h0);
    endtask

    task automatic t_busy();
        bit seen = 1'b0;
        tx_frame_busy = 1'b1;
        cfg_quanta = 16'h00FF;
        pulse_cmd();
        repeat (30) begin
            if (gen_valid) seen = 1'b1;
            @(negedge clk);
        end
        check_eq("R9", "no frame while busy", seen, 0);
        check_eq("R8", "hold while pending", tx_hold, 1);
        tx_frame_busy = 1'b0;
        capture("R9", 16'h00FF, 1'b0, 16'h0);
    endtask

    task automatic t_hw();
        bit seen = 1'b0;
        cfg_quanta = 16'h0A0B;
        cfg_xoff_hw_disable = 1'b1;
        xoff_req = 1'b1;
        repeat (20) begin
            if (gen_valid) seen = 1'b1;
            @(negedge clk);
        end
        check_eq("R11", "masked xoff no frame", seen, 0);
        check_eq("R11", "masked xoff no hold", tx_hold, 0);
        xoff_req = 1'b0;
        cfg_xoff_hw_disable = 1'b0;
        @(negedge clk);
        xoff_req = 1'b1;
        capture("R11", 16'h0A0B, 1'b0, 16'h0);
        seen = 1'b0;
        repeat (100) begin
            if (gen_valid) seen = 1'b1;
            @(negedge clk);
        end
        check_eq("R11", "held xoff single frame", seen, 0);
        xoff_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_latch();
        cfg_quanta = 16'hABCD;
        pulse_cmd();
        capture("R12", 16'hABCD, 1'b1, 16'h0F0F);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reject();
        t_ignore();
        t_tick();
        t_zero();
        t_reload();
        t_gen_cmd();
        t_busy();
        t_hw();
        t_latch();
        finish_run();
    end
endmodule